// File: doc/BRIEF.md
# Serial Unlock Pattern Recognizer

This block sits beside a parallel memory and watches its bus strobes (chip enable, output enable, write enable) and the lowest data line. A hidden register port may take over the bus only after software runs an unlock ritual. First it issues any read cycle, which arms the recognizer and sets its compare pointer to key bit 0. Then it issues 64 write cycles whose data bit 0 spells out a 64-bit key, least significant bit first. All of these cycles still reach the memory array, so software normally sets aside one scratch word for them.

The strobes are asynchronous. Each one passes through a two-flop synchronizer into the block clock. A bus cycle is recognised when the synchronized chip enable falls. At that point write enable low marks a write, and output enable low with write enable high marks a read. A mismatching write freezes the matcher until the next read. After a full match, the block opens a transfer window of exactly 64 selected cycles, reads or writes. During the window it raises an unlocked flag, gives the index of the cycle in progress to a transfer engine, and inhibits the memory array whenever chip enable is active.

Top module: `serial_unlock_top`

## Requirements
- R1: After reset unlocked_o, mem_inhibit_o and xfer_idx_o are 0. Key writes with no read since reset never unlock.
- R2: After a read cycle, 64 write cycles whose data bit 0 matches the key raise unlocked_o once chip enable returns high after the 64th write.
- R3: mem_inhibit_o stays low during every write cycle used for matching, including the 64th.
- R4: A write whose data bit 0 differs from the key bit at the pointer freezes matching. No later write unlocks, whatever its data, until a read.
- R5: A read cycle during recognition discards the progress made so far. A full unlock then needs all 64 key bits after that read.
- R6: Toggling output enable, write enable or data while chip enable is high does not disturb recognition.
- R7: A chip enable falling edge with both write enable and output enable high is neither a read nor a write, and it leaves recognition unchanged.
- R8: While unlocked_o is high, mem_inhibit_o is high whenever chip enable is low and low whenever chip enable is high.
- R9: The transfer window lasts exactly 64 selected read or write cycles. xfer_idx_o counts the window cycles seen so far (0 to 64). unlocked_o falls once chip enable rises after the 64th cycle, and xfer_idx_o then returns to 0.
- R10: Once a window closes, the matcher stays disarmed. The key unlocks again only after a new read cycle.
- R11: The key is the parameter KEY. Bit i of KEY is compared with data bit 0 of the i-th write after the arming read, counting from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Bus chip enable, active low |
| oe_ni | input | 1 | Bus output enable, active low |
| we_ni | input | 1 | Bus write enable, active low |
| dq0_i | input | 1 | Bus data bit 0 |
| unlocked_o | output | 1 | Transfer window open |
| mem_inhibit_o | output | 1 | Blocks the memory array during window cycles |
| xfer_idx_o | output | 7 | Window cycles seen so far |

## Verification
The full key is played after a read, and separately with no read at all, which shows that arming is required. A single wrong bit at position 5 followed by correct bits shows that a mismatch freezes the matcher rather than skipping the bit. A read after 20 good bits, followed first by only the remaining 44 bits and then by a fresh full key, shows that a read restarts the compare from bit 0. A key run with deselected strobe toggling and strobe-less chip enable pulses mixed in shows that those events are filtered out. The window is walked with mixed reads and writes to pin its length, its index and how the inhibit output follows chip enable.

// File: rtl/serial_unlock_pkg.sv
package serial_unlock_pkg;
  typedef enum logic [1:0] {
    SESS_IDLE,
    SESS_START,
    SESS_XFER,
    SESS_DRAIN
  } sess_state_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic dat;
  } bus_evt_t;
endpackage

// File: rtl/unlock_bus_sync.sv
module unlock_bus_sync
  import serial_unlock_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ce_ni,
  input  logic     oe_ni,
  input  logic     we_ni,
  input  logic     dq0_i,
  output bus_evt_t evt_o,
  output logic     ce_rise_o
);
  localparam int NSIG = 4;
  localparam logic [NSIG-1:0] RST_VAL = 4'b1110; // ce, oe, we idle high; dq 0

  logic [NSIG-1:0] sync_q [SYNC_STAGES];
  logic            ce_prev_q;
  logic            ce_s, oe_s, we_s, dq_s;
  logic            ce_fall, ce_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= RST_VAL;
    else         sync_q[0] <= {ce_ni, oe_ni, we_ni, dq0_i};
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= RST_VAL;
      else         sync_q[s] <= sync_q[s-1];
    end
  end

  assign {ce_s, oe_s, we_s, dq_s} = sync_q[SYNC_STAGES-1];
  assign ce_fall = ce_prev_q & ~ce_s;
  assign ce_rise = ~ce_prev_q & ce_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_prev_q <= 1'b1;
      evt_o     <= '0;
      ce_rise_o <= 1'b0;
    end else begin
      ce_prev_q <= ce_s;
      evt_o.wr  <= ce_fall & ~we_s;
      evt_o.rd  <= ce_fall & we_s & ~oe_s;
      evt_o.dat <= dq_s;
      ce_rise_o <= ce_rise;
    end
  end

  assert_evt_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_o.rd && evt_o.wr));
  assert_edge_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_rise_o |-> !(evt_o.rd || evt_o.wr));
endmodule

// File: rtl/unlock_key_match.sv
module unlock_key_match #(
  parameter int          KEY_LEN = 64,
  parameter logic [63:0] KEY     = 64'h0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic wr_i,
  input  logic bit_i,
  input  logic busy_i,
  output logic match_o
);
  localparam int PTR_W = $clog2(KEY_LEN);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(KEY_LEN - 1);

  logic [PTR_W-1:0] ptr_q;
  logic             armed_q, miss_q;
  logic             live, bit_ok;

  assign live    = armed_q & ~miss_q & ~busy_i;
  assign bit_ok  = (bit_i == KEY[ptr_q]);
  assign match_o = wr_i & live & bit_ok & (ptr_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      armed_q <= 1'b0;
      miss_q  <= 1'b0;
    end else if (!busy_i) begin
      if (rd_i) begin
        ptr_q   <= '0;
        armed_q <= 1'b1;
        miss_q  <= 1'b0;
      end else if (wr_i && live) begin
        if (!bit_ok) begin
          miss_q <= 1'b1;
        end else if (ptr_q == LAST) begin
          ptr_q   <= '0;
          armed_q <= 1'b0; // next attempt needs a fresh read
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end

  assert_miss_freezes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_q && !rd_i) |=> $stable(ptr_q));
  assert_read_rearms_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !busy_i) |=> (ptr_q == '0 && armed_q && !miss_q));
  assert_match_disarms_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !armed_q);
endmodule

// File: rtl/unlock_session.sv
module unlock_session
  import serial_unlock_pkg::*;
#(
  parameter int XFER_LEN = 64,
  parameter int CNT_W    = $clog2(XFER_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             match_i,
  input  logic             cyc_i,
  input  logic             ce_rise_i,
  output logic             busy_o,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(XFER_LEN - 1);

  sess_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SESS_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SESS_IDLE:  if (match_i) state_q <= SESS_START;
        // key write still selected: open the window once ce rises
        SESS_START: if (ce_rise_i) begin
          state_q <= SESS_XFER;
          cnt_q   <= '0;
        end
        SESS_XFER: if (cyc_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= SESS_DRAIN;
        end
        SESS_DRAIN: if (ce_rise_i) begin
          state_q <= SESS_IDLE;
          cnt_q   <= '0;
        end
        default: state_q <= SESS_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != SESS_IDLE);
  assign active_o = (state_q == SESS_XFER) || (state_q == SESS_DRAIN);
  assign cnt_o    = cnt_q;

  assert_cnt_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(XFER_LEN));
  assert_drain_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SESS_DRAIN) |-> (cnt_q == CNT_W'(XFER_LEN)));
  assert_idle_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SESS_IDLE) |-> (cnt_q == '0));
endmodule

// File: rtl/serial_unlock_top.sv
module serial_unlock_top
  import serial_unlock_pkg::*;
#(
  parameter int          KEY_LEN     = 64,
  parameter logic [63:0] KEY         = 64'h5CA3_3AC5_0F1E_96E1,
  parameter int          XFER_LEN    = 64,
  parameter int          SYNC_STAGES = 2,
  parameter int          IDX_W       = $clog2(XFER_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_ni,
  input  logic             oe_ni,
  input  logic             we_ni,
  input  logic             dq0_i,
  output logic             unlocked_o,
  output logic             mem_inhibit_o,
  output logic [IDX_W-1:0] xfer_idx_o
);
  bus_evt_t evt;
  logic     ce_rise, match, busy, active;

  unlock_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .dq0_i,
    .evt_o(evt), .ce_rise_o(ce_rise)
  );

  unlock_key_match #(.KEY_LEN(KEY_LEN), .KEY(KEY)) u_match (
    .clk_i, .rst_ni, .rd_i(evt.rd), .wr_i(evt.wr), .bit_i(evt.dat),
    .busy_i(busy), .match_o(match)
  );

  unlock_session #(.XFER_LEN(XFER_LEN), .CNT_W(IDX_W)) u_sess (
    .clk_i, .rst_ni, .match_i(match), .cyc_i(evt.rd | evt.wr),
    .ce_rise_i(ce_rise), .busy_o(busy), .active_o(active), .cnt_o(xfer_idx_o)
  );

  assign unlocked_o    = active;
  assign mem_inhibit_o = active & ~ce_ni;

  assert_key_write_not_inhibited_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |-> !mem_inhibit_o);
  assert_no_match_in_window_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlocked_o |-> !match);
endmodule

// File: tb/serial_unlock_top_test.sv
module serial_unlock_top_test;
  localparam logic [63:0] KEY = 64'hA55A_C3E1_0F96_3C71;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, dq0 = 1'b0;
  logic       unlocked, inhibit;
  logic [6:0] idx;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  serial_unlock_top #(.KEY(KEY)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .dq0_i(dq0), .unlocked_o(unlocked), .mem_inhibit_o(inhibit), .xfer_idx_o(idx)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // kind: 0 read, 1 write, 2 strobe-less select; checks inhibit while selected
  task automatic bus_cyc(input int kind, input logic b, input logic exp_inh, input string req);
    oe_n = (kind == 0) ? 1'b0 : 1'b1;
    we_n = (kind == 1) ? 1'b0 : 1'b1;
    dq0  = b;
    wait_n(2);
    ce_n = 1'b0;
    wait_n(6);
    chk(req, inhibit, exp_inh);
    ce_n = 1'b1;
    wait_n(2);
    chk(req, inhibit, 1'b0);
    oe_n = 1'b1; we_n = 1'b1;
    wait_n(4);
  endtask

  task automatic key_run(input int from, input int upto, input string req);
    for (int i = from; i < upto; i++) bus_cyc(1, KEY[i], 1'b0, req);
  endtask

  task automatic close_window;
    for (int i = 0; i < 64; i++) bus_cyc(i % 3 == 0 ? 0 : 1, 1'b0, 1'b1, "R8");
    chk("R9", unlocked, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1", unlocked, 1'b0);
    chk("R1", inhibit, 1'b0);
    chk("R1", idx, 7'd0);
    key_run(0, 64, "R1");
    chk("R1", unlocked, 1'b0);
  endtask

  task automatic t_unlock_and_window;
    bus_cyc(0, 1'b0, 1'b0, "R2");
    key_run(0, 63, "R3");
    chk("R11", unlocked, 1'b0);
    bus_cyc(1, KEY[63], 1'b0, "R3");
    chk("R2", unlocked, 1'b1);
    chk("R9", idx, 7'd0);
    for (int i = 0; i < 63; i++) begin
      bus_cyc(i % 2, 1'b1, 1'b1, "R8");
      chk("R9", idx, 7'(i + 1));
    end
    chk("R9", unlocked, 1'b1);
    bus_cyc(1, 1'b0, 1'b1, "R8");
    chk("R9", unlocked, 1'b0);
    chk("R9", idx, 7'd0);
  endtask

  task automatic t_rearm;
    key_run(0, 64, "R10");
    chk("R10", unlocked, 1'b0);
    bus_cyc(0, 1'b0, 1'b0, "R10");
    key_run(0, 64, "R10");
    chk("R10", unlocked, 1'b1);
    close_window();
  endtask

  task automatic t_mismatch;
    bus_cyc(0, 1'b0, 1'b0, "R4");
    key_run(0, 5, "R4");
    bus_cyc(1, ~KEY[5], 1'b0, "R4");
    key_run(6, 64, "R4");
    chk("R4", unlocked, 1'b0);
    key_run(0, 64, "R4");
    chk("R4", unlocked, 1'b0);
  endtask

  task automatic t_abort;
    bus_cyc(0, 1'b0, 1'b0, "R5");
    key_run(0, 20, "R5");
    bus_cyc(0, 1'b0, 1'b0, "R5");
    key_run(20, 64, "R5");
    chk("R5", unlocked, 1'b0);
    bus_cyc(0, 1'b0, 1'b0, "R5");
    key_run(0, 30, "R5");
    bus_cyc(0, 1'b0, 1'b0, "R5");
    key_run(0, 64, "R5");
    chk("R5", unlocked, 1'b1);
    close_window();
  endtask

  task automatic t_noise;
    bus_cyc(0, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 64; i++) begin
      bus_cyc(1, KEY[i], 1'b0, "R6");
      if (i % 8 == 3) begin
        oe_n = 1'b0; dq0 = ~dq0; wait_n(3);
        we_n = 1'b0; wait_n(3);
        oe_n = 1'b1; we_n = 1'b1; wait_n(3);
      end
      if (i % 8 == 5) bus_cyc(2, ~KEY[i+1], 1'b0, "R7");
    end
    chk("R6", unlocked, 1'b1);
    close_window();
    chk("R7", idx, 7'd0);
  endtask

  initial begin
    fork
      begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(3);
        t_reset();
        t_unlock_and_window();
        t_rearm();
        t_mismatch();
        t_abort();
        t_noise();
      end
      begin
        wait_n(150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule